// File: doc/BRIEF.md
# Retro CPU Glue Decoder

This block is the glue logic of an 8-bit CPU board with a 20-bit address bus. It sees the CPU's address, its memory and I/O request strobes, its read, write and opcode-fetch (M1) strobes, and its clock. It drives active-low enables for three 512 KiB memory devices: a boot flash ROM, a low RAM and a high RAM. Address bit 19 picks the half of the 1 MiB space. The upper half always belongs to the high RAM. The lower half belongs to the ROM after reset, so the CPU starts from boot code. Once the CPU writes 1 to a one-bit mapping register, the lower half belongs to the low RAM.

On the I/O side, the block splits the window 0xF0..0xFF into eight slots of two addresses each. The slot at 0xF0 serves a storage host, the slot at 0xF2 serves a floating-point coprocessor, and the other six go to an expansion connector. Address bit 0 is passed on to the selected device. The block also divides the CPU clock by four for the coprocessor.

A byte channel to a console controller sits next to the mapping register, below the slot window. Both of its directions are valid/ready streams. On the outgoing side, a byte stays valid and unchanged until the console takes it with ready high. On the incoming side, the block raises ready only while its one-byte holding register is empty, so a full register applies back-pressure to the console.

Top module: `x80_glue`

## Requirements
- R1: After reset the mapping bit is 0, `cop_clk` is low, `con_tx_valid` is low and `con_rx_ready` is high. A read of I/O port 0xE0 returns 0x00.
- R2: With `mreq_n` low, `iorq_n` high and `addr[19]`=1, only `ram_hi_cs_n` is low, whatever the state of the mapping bit.
- R3: With `mreq_n` low, `iorq_n` high and `addr[19]`=0, `rom_cs_n` is low when the mapping bit is 0 and `ram_lo_cs_n` is low when it is 1. At most one memory select is ever low. None is low while `mreq_n` is high or `iorq_n` is low.
- R4: A CPU I/O write to port 0xE0 loads data bit 0 into the mapping bit. A read of port 0xE0 returns {7'b0, mapping bit}.
- R5: With `iorq_n` low, `m1_n` high and low-byte address bits 7:4 equal to 0xF, `io_cs_n[addr[3:1]]` is the only low I/O select and `io_a0` equals `addr[0]`. For any other low byte, all I/O selects are high.
- R6: During interrupt acknowledge (`iorq_n` and `m1_n` both low), no I/O select is low and no register port is written or read.
- R7: `cop_clk` has a period of four `clk` cycles and a 50% duty cycle. It rises on the 2nd rising edge after reset is released and then toggles every 2nd edge.
- R8: An I/O write to port 0xE2 while the outgoing byte is free loads `con_tx_data` and raises `con_tx_valid`. The byte stays stable until a cycle with `con_tx_ready` high. A write while the byte is still pending is ignored.
- R9: An incoming byte is taken on an edge where `con_rx_valid` and `con_rx_ready` are both high. `con_rx_ready` is low while the byte is held. Port 0xE3 reads bit0 = byte held and bit1 = outgoing free. A read of port 0xE2 returns the held byte and frees the holding register once the read strobe ends.
- R10: `dout_en` is high only while `rd_n` is low during a non-acknowledge I/O cycle at port 0xE0, 0xE2 or 0xE3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 20 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | CPU write data |
| dout | output | 8 | Register read data |
| dout_en | output | 1 | Drive enable for `dout` |
| rom_cs_n | output | 1 | Flash ROM select |
| ram_lo_cs_n | output | 1 | Low RAM select |
| ram_hi_cs_n | output | 1 | High RAM select |
| io_cs_n | output | 8 | I/O slot selects, slot n covers 0xF0+2n and 0xF1+2n |
| io_a0 | output | 1 | Register select passed to the I/O device |
| cop_clk | output | 1 | Coprocessor clock, `clk`/4 |
| con_rx_data | input | 8 | Byte from the console |
| con_rx_valid | input | 1 | Console byte valid |
| con_rx_ready | output | 1 | Holding register free |
| con_tx_data | output | 8 | Byte to the console |
| con_tx_valid | output | 1 | Outgoing byte valid |
| con_tx_ready | input | 1 | Console accepts byte |

## Verification
A wrong mapping bit shows on the very next lower-half memory access: the ROM and low-RAM selects swap. It also shows as the wrong value in a read of port 0xE0. A divider that has slipped phase or rate shows as a wrong `cop_clk` level within four cycles of reset. A lost or stale console flag shows on the next access to the status port, and as a `con_rx_ready` or `con_tx_valid` level that contradicts the last transfer. Chip select errors are combinational and show within the same bus cycle.

// File: rtl/x80_glue_pkg.sv
package x80_glue_pkg;
  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 8;
  localparam int IO_SLOTS  = 8;
  localparam int SLOT_W    = $clog2(IO_SLOTS);
  localparam logic [3:0] SLOT_HI = 4'hF;
  localparam logic [7:0] PORT_MAP  = 8'hE0;
  localparam logic [7:0] PORT_CDAT = 8'hE2;
  localparam logic [7:0] PORT_CSTA = 8'hE3;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_MAP  = 2'd1,
    RSEL_DATA = 2'd2,
    RSEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/x80_mem_decode.sv
module x80_mem_decode
  import x80_glue_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic          map_ram,
  output logic          rom_cs_n,
  output logic          ram_lo_cs_n,
  output logic          ram_hi_cs_n
);
  localparam int HALF_BIT = AW - 1;

  logic mem_cycle;
  logic upper;

  assign mem_cycle   = !mreq_n && iorq_n;
  assign upper       = addr[HALF_BIT];
  assign ram_hi_cs_n = !(mem_cycle && upper);
  assign ram_lo_cs_n = !(mem_cycle && !upper && map_ram);
  assign rom_cs_n    = !(mem_cycle && !upper && !map_ram);

  AST_MEM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rom_cs_n, !ram_lo_cs_n, !ram_hi_cs_n})); // R3
  AST_MEM_QUIET_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n || mreq_n) |-> (rom_cs_n && ram_lo_cs_n && ram_hi_cs_n)); // R3
endmodule

// File: rtl/x80_io_decode.sv
module x80_io_decode
  import x80_glue_pkg::*;
#(
  parameter int          SLOTS = IO_SLOTS,
  parameter logic [7:0]  P_MAP = PORT_MAP,
  parameter logic [7:0]  P_DAT = PORT_CDAT,
  parameter logic [7:0]  P_STA = PORT_CSTA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       port,
  input  logic             iorq_n,
  input  logic             m1_n,
  output logic [SLOTS-1:0] io_cs_n,
  output logic             io_a0,
  output reg_sel_e         rsel
);
  localparam int SW = $clog2(SLOTS);

  logic          io_cycle;
  logic          window;
  logic [SW-1:0] slot;

  assign io_cycle = !iorq_n && m1_n;
  assign window   = io_cycle && (port[7:4] == SLOT_HI);
  assign slot     = port[SW:1];
  assign io_a0    = port[0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign io_cs_n[s] = !(window && (slot == SW'(s)));
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (io_cycle) begin
      if (port == P_MAP)      rsel = RSEL_MAP;
      else if (port == P_DAT) rsel = RSEL_DATA;
      else if (port == P_STA) rsel = RSEL_STAT;
    end
  end

  AST_IO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~io_cs_n)); // R5
  AST_IO_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !m1_n) |-> (&io_cs_n)); // R6
  AST_IO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |-> (&io_cs_n)); // R5
endmodule

// File: rtl/x80_ctrl_regs.sv
module x80_ctrl_regs
  import x80_glue_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  input  reg_sel_e      rsel,
  output logic          map_ram,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic [DW-1:0] con_rx_data,
  input  logic          con_rx_valid,
  output logic          con_rx_ready,
  output logic [DW-1:0] con_tx_data,
  output logic          con_tx_valid,
  input  logic          con_tx_ready
);
  logic          wr_seen_q;
  logic          wr_evt;
  logic          pop_arm_q;
  logic          rx_full_q;
  logic [DW-1:0] rx_byte_q;

  assign wr_evt       = !wr_n && !wr_seen_q;
  assign con_rx_ready = !rx_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen_q <= 1'b0;
      map_ram   <= 1'b0;
    end else begin
      wr_seen_q <= !wr_n;
      if (wr_evt && rsel == RSEL_MAP) map_ram <= din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      con_tx_valid <= 1'b0;
      con_tx_data  <= '0;
    end else if (con_tx_valid) begin
      if (con_tx_ready) con_tx_valid <= 1'b0;
    end else if (wr_evt && rsel == RSEL_DATA) begin
      con_tx_valid <= 1'b1;
      con_tx_data  <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      rx_byte_q <= '0;
      pop_arm_q <= 1'b0;
    end else begin
      if (!rx_full_q && con_rx_valid) begin
        rx_full_q <= 1'b1;
        rx_byte_q <= con_rx_data;
      end
      if (!rd_n && rsel == RSEL_DATA && rx_full_q) pop_arm_q <= 1'b1;
      else if (rd_n && pop_arm_q) begin
        pop_arm_q <= 1'b0;
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    dout_en = !rd_n && (rsel != RSEL_NONE);
    unique case (rsel)
      RSEL_MAP:  dout = {{(DW-1){1'b0}}, map_ram};
      RSEL_DATA: dout = rx_byte_q;
      RSEL_STAT: dout = {{(DW-2){1'b0}}, !con_tx_valid, rx_full_q};
      default:   dout = '0;
    endcase
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (con_tx_valid && !con_tx_ready) |=> (con_tx_valid && $stable(con_tx_data))); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!con_rx_ready && rd_n && !pop_arm_q) |=> (!con_rx_ready && $stable(rx_byte_q))); // R9
endmodule

// File: rtl/x80_clk_div.sv
module x80_clk_div #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic div_clk
);
  localparam int CW = $clog2(RATIO);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign div_clk = cnt_q[CW-1];

  AST_DIV_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |=> div_clk); // R7
  AST_DIV_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk) |=> !div_clk); // R7
endmodule

// File: rtl/x80_glue.sv
module x80_glue
  import x80_glue_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int SLOTS = IO_SLOTS,
  parameter int RATIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             mreq_n,
  input  logic             iorq_n,
  input  logic             m1_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en,
  output logic             rom_cs_n,
  output logic             ram_lo_cs_n,
  output logic             ram_hi_cs_n,
  output logic [SLOTS-1:0] io_cs_n,
  output logic             io_a0,
  output logic             cop_clk,
  input  logic [DW-1:0]    con_rx_data,
  input  logic             con_rx_valid,
  output logic             con_rx_ready,
  output logic [DW-1:0]    con_tx_data,
  output logic             con_tx_valid,
  input  logic             con_tx_ready
);
  logic     map_ram;
  reg_sel_e rsel;

  x80_mem_decode #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .map_ram(map_ram), .rom_cs_n(rom_cs_n), .ram_lo_cs_n(ram_lo_cs_n),
    .ram_hi_cs_n(ram_hi_cs_n)
  );

  x80_io_decode #(.SLOTS(SLOTS)) u_io (
    .clk(clk), .rst_n(rst_n), .port(addr[7:0]), .iorq_n(iorq_n), .m1_n(m1_n),
    .io_cs_n(io_cs_n), .io_a0(io_a0), .rsel(rsel)
  );

  x80_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .din(din), .rsel(rsel),
    .map_ram(map_ram), .dout(dout), .dout_en(dout_en),
    .con_rx_data(con_rx_data), .con_rx_valid(con_rx_valid),
    .con_rx_ready(con_rx_ready), .con_tx_data(con_tx_data),
    .con_tx_valid(con_tx_valid), .con_tx_ready(con_tx_ready)
  );

  x80_clk_div #(.RATIO(RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .div_clk(cop_clk)
  );
endmodule

// File: tb/test_x80_glue.sv
module test_x80_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, rom_cs_n, ram_lo_cs_n, ram_hi_cs_n, io_a0, cop_clk;
  logic [7:0]  io_cs_n;
  logic [7:0]  con_rx_data = '0;
  logic        con_rx_valid = 1'b0;
  logic        con_rx_ready;
  logic [7:0]  con_tx_data;
  logic        con_tx_valid;
  logic        con_tx_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  x80_glue i_x80_glue (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout),
    .dout_en(dout_en), .rom_cs_n(rom_cs_n), .ram_lo_cs_n(ram_lo_cs_n),
    .ram_hi_cs_n(ram_hi_cs_n), .io_cs_n(io_cs_n), .io_a0(io_a0),
    .cop_clk(cop_clk), .con_rx_data(con_rx_data), .con_rx_valid(con_rx_valid),
    .con_rx_ready(con_rx_ready), .con_tx_data(con_tx_data),
    .con_tx_valid(con_tx_valid), .con_tx_ready(con_tx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] p, input logic [7:0] d, input logic m1v);
    @(negedge clk);
    addr = {12'h000, p}; din = d; iorq_n = 1'b0; m1_n = m1v; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic io_read(input logic [7:0] p, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = {12'h000, p}; iorq_n = 1'b0; m1_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    d = dout; en = dout_en;
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       en;
    logic [7:0] exp_cs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: level after the k-th rising edge since release
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(cop_clk == ((k % 4) >= 2), "R7 cop_clk phase", cop_clk, int'((k % 4) >= 2));
    end
    // R1: reset state
    chk(con_tx_valid == 1'b0, "R1 tx_valid", con_tx_valid, 0);
    chk(con_rx_ready == 1'b1, "R1 rx_ready", con_rx_ready, 1);
    io_read(8'hE0, rd, en);
    chk(rd == 8'h00, "R1 map after reset", rd, 0);
    chk(en == 1'b1, "R10 dout_en on map read", en, 1);

    // R2/R3: memory sweep, mapping bit in both states
    for (int m = 0; m < 2; m++) begin
      io_write(8'hE0, 8'(m), 1'b1);
      io_read(8'hE0, rd, en);
      chk(rd == 8'(m), "R4 map readback", rd, m);
      for (int hi = 0; hi < 2; hi++) begin
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          addr = {hi[0], 19'(k * 32'h6A3B1)}; mreq_n = 1'b0;
          #1;
          if (hi == 1)
            chk({rom_cs_n, ram_lo_cs_n, ram_hi_cs_n} == 3'b110, "R2 upper half",
                {rom_cs_n, ram_lo_cs_n, ram_hi_cs_n}, 3'b110);
          else
            chk({rom_cs_n, ram_lo_cs_n, ram_hi_cs_n} == ((m == 1) ? 3'b101 : 3'b011),
                "R3 lower half", {rom_cs_n, ram_lo_cs_n, ram_hi_cs_n},
                (m == 1) ? 3'b101 : 3'b011);
          iorq_n = 1'b0; // R3: memory request overlapped with I/O request
          #1;
          chk({rom_cs_n, ram_lo_cs_n, ram_hi_cs_n} == 3'b111, "R3 no select in io",
              {rom_cs_n, ram_lo_cs_n, ram_hi_cs_n}, 3'b111);
          iorq_n = 1'b1; mreq_n = 1'b1;
          #1;
          chk({rom_cs_n, ram_lo_cs_n, ram_hi_cs_n} == 3'b111, "R3 idle",
              {rom_cs_n, ram_lo_cs_n, ram_hi_cs_n}, 3'b111);
        end
      end
    end

    // R5: full low-byte I/O sweep
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      addr = {12'hABC, 8'(a)}; iorq_n = 1'b0; m1_n = 1'b1;
      #1;
      exp_cs = (a[7:4] == 4'hF) ? ~(8'h01 << a[3:1]) : 8'hFF;
      chk(io_cs_n == exp_cs, "R5 io slot", io_cs_n, exp_cs);
      if (a[7:4] == 4'hF) chk(io_a0 == a[0], "R5 io_a0", io_a0, a[0]);
      // R6: acknowledge
      m1_n = 1'b0;
      #1;
      chk(io_cs_n == 8'hFF, "R6 no select in ack", io_cs_n, 8'hFF);
      m1_n = 1'b1; iorq_n = 1'b1;
    end

    // R6: acknowledge write to map port ignored; map is 1 here
    io_write(8'hE0, 8'h00, 1'b0);
    io_read(8'hE0, rd, en);
    chk(rd == 8'h01, "R6 ack write ignored", rd, 1);
    // R10: read outside register ports
    io_read(8'hF4, rd, en);
    chk(en == 1'b0, "R10 no drive at F4", en, 0);
    @(negedge clk);
    addr = 20'h000E0; iorq_n = 1'b0; m1_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(dout_en == 1'b0, "R10 no drive in ack", dout_en, 0);
    iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1;
    io_write(8'hE0, 8'hFE, 1'b1);
    io_read(8'hE0, rd, en);
    chk(rd == 8'h00, "R4 data bit0 only", rd, 0);

    // R8: outgoing stream
    io_write(8'hE2, 8'hA5, 1'b1);
    chk(con_tx_valid == 1'b1, "R8 tx valid", con_tx_valid, 1);
    chk(con_tx_data == 8'hA5, "R8 tx data", con_tx_data, 8'hA5);
    io_read(8'hE3, rd, en);
    chk(rd[1] == 1'b0, "R9 status tx busy", rd[1], 0);
    io_write(8'hE2, 8'h3C, 1'b1);
    chk(con_tx_data == 8'hA5, "R8 write while busy ignored", con_tx_data, 8'hA5);
    @(negedge clk); con_tx_ready = 1'b1;
    @(negedge clk); con_tx_ready = 1'b0;
    chk(con_tx_valid == 1'b0, "R8 tx taken", con_tx_valid, 0);

    // R9: incoming stream
    @(negedge clk); con_rx_data = 8'h5A; con_rx_valid = 1'b1;
    @(negedge clk); con_rx_data = 8'h77;
    chk(con_rx_ready == 1'b0, "R9 rx ready low when full", con_rx_ready, 0);
    @(negedge clk); con_rx_valid = 1'b0;
    io_read(8'hE3, rd, en);
    chk(rd == 8'h03, "R9 status full and tx free", rd, 3);
    io_read(8'hE2, rd, en);
    chk(rd == 8'h5A, "R9 rx data", rd, 8'h5A);
    io_read(8'hE3, rd, en);
    chk(rd[0] == 1'b0, "R9 freed after read", rd[0], 0);
    chk(con_rx_ready == 1'b1, "R9 rx ready again", con_rx_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule